// File: doc/BRIEF.md
# Turbo CPU External Bus Pacer

This block sits between a CPU core that runs at twice the standard peripheral bus rate and a slower external bus. For every CPU access it takes the decoded attributes (memory or I/O, read or write, internal fast path or external bus, and whether the target is the video processor's video-memory data port). It then holds the CPU wait line so that each access lasts the number of fast cycles that slow-bus timing requires. External memory accesses take 4 fast cycles, which is 2 bus cycles. External I/O accesses take 6 fast cycles, which is 3 bus cycles. Internal accesses run in a single cycle.

An external I/O access to the video data port can be extended further by the video processor's active-low wait output. That output is first brought into the fast clock domain through a two-stage synchroniser and is honoured only when its enable is set. Register-port I/O to the same chip is never extended beyond normal I/O timing. A compatibility mode slows every access, internal ones included, to slow-bus timing. The block comes out of reset in that mode, and the mode input is sampled only between accesses.

The CPU raises `cpu_req_i` together with the attributes and holds them steady until it sees `cpu_wait_o` low in the same cycle. The access completes at that clock edge. A new access, or the same request held high, is accepted on the next cycle.

Top module: `turbo_bus_pacer`

## Requirements
- R1: After reset the block is in compatibility mode, `cpu_wait_o` is low while no request is present, and all four bus strobes (`bus_mreq_no`, `bus_iorq_no`, `bus_rd_no`, `bus_wr_no`) are high (inactive).
- R2: In turbo mode an access with `tgt_ext_i`=0 completes in the cycle it is presented (`cpu_wait_o` low, 1 cycle) and asserts no bus strobe.
- R3: An external memory access (`tgt_ext_i`=1, `cpu_io_i`=0) lasts exactly 4 cycles (wait high in the first 3, low in the 4th), with `bus_mreq_no` low and `bus_rd_no` (when `cpu_wr_i`=0) or `bus_wr_no` (when `cpu_wr_i`=1) low in all 4 cycles, in either mode.
- R4: An external I/O access (`cpu_io_i`=1) lasts exactly 6 cycles, with `bus_iorq_no` and the matching read/write strobe low in all 6 cycles and `bus_mreq_no` high.
- R5: In compatibility mode an internal access also lasts 4 cycles (memory) or 6 cycles (I/O), but asserts no bus strobe.
- R6: During an external I/O access with `tgt_vdata_i`=1 and `vwait_en_i`=1, a low level on `vwait_ni` holds the CPU in wait on top of the counted cycles. The pin reaches the wait logic two clock edges after it changes, so if it rises at the start of relative cycle k (cycle 0 being the first cycle of the access), the access lasts max(6, k+3) cycles.
- R7: A low `vwait_ni` has no effect on access length when `vwait_en_i`=0, when `tgt_vdata_i`=0 (register-port I/O), or when the access is not external I/O.
- R8: All strobes deassert after the edge on which the wait releases, and a request presented in the very next cycle starts a new access with its own full length.
- R9: `turbo_en_i` is sampled only in cycles with no access in progress: changing it during an access leaves that access's length unchanged, and the new mode applies after at least one idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast CPU clock (twice the bus rate) |
| rst_ni | input | 1 | Synchronous active-low reset |
| turbo_en_i | input | 1 | 1 selects turbo mode, 0 compatibility mode |
| cpu_req_i | input | 1 | CPU access request, held until wait releases |
| cpu_io_i | input | 1 | 1 for I/O, 0 for memory |
| cpu_wr_i | input | 1 | 1 for write, 0 for read |
| tgt_ext_i | input | 1 | Decoded target is on the external bus |
| tgt_vdata_i | input | 1 | Decoded target is the video-memory data port |
| vwait_en_i | input | 1 | Enables the video processor wait |
| vwait_ni | input | 1 | Video processor wait, active low, asynchronous |
| cpu_wait_o | output | 1 | Wait to the CPU, high stalls the access |
| bus_mreq_no | output | 1 | External memory request strobe, active low |
| bus_iorq_no | output | 1 | External I/O request strobe, active low |
| bus_rd_no | output | 1 | External read strobe, active low |
| bus_wr_no | output | 1 | External write strobe, active low |

## Verification
A wrong wait counter or a stale latched attribute shows up at the ports within the affected access. The wait release moves by one or more cycles, or the strobe pattern changes, so the bench measures the length of every access in cycles and compares the strobes in each of those cycles. A mode register that updates at the wrong moment changes the length of the access that follows the toggle. A fault in the synchroniser shifts the video-wait extension by a whole cycle against the max(6, k+3) rule, which the randomised release times expose.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

    // Attributes of one CPU access, latched when a stretched access is accepted
    typedef struct packed {
        logic ext;    // target on the external bus
        logic io;     // I/O rather than memory
        logic wr;     // write rather than read
        logic vdata;  // video-memory data port
    } acc_attr_t;

endpackage

// File: rtl/pacer_sync.sv
module pacer_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] stg_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk_i) begin
                if (!rst_ni) stg_q <= RST_VAL;
                else         stg_q <= d_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk_i) begin
                if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
                else         stg_q <= {stg_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pacer_len.sv
module pacer_len #(
    parameter int MEM_CYC = 4,
    parameter int IO_CYC  = 6,
    parameter int CNT_W   = 3
) (
    input  logic             turbo_i,
    input  logic             ext_i,
    input  logic             io_i,
    output logic             stretch_o,
    output logic [CNT_W-1:0] load_o
);
    // Counted wait cycles after the first cycle, minus the release cycle
    localparam logic [CNT_W-1:0] MEM_LOAD = CNT_W'(MEM_CYC - 2);
    localparam logic [CNT_W-1:0] IO_LOAD  = CNT_W'(IO_CYC - 2);

    always_comb begin
        stretch_o = ext_i | ~turbo_i;
        load_o    = io_i ? IO_LOAD : MEM_LOAD;
    end
endmodule

// File: rtl/turbo_bus_pacer.sv
module turbo_bus_pacer #(
    parameter int MEM_CYC     = 4,
    parameter int IO_CYC      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic turbo_en_i,
    input  logic cpu_req_i,
    input  logic cpu_io_i,
    input  logic cpu_wr_i,
    input  logic tgt_ext_i,
    input  logic tgt_vdata_i,
    input  logic vwait_en_i,
    input  logic vwait_ni,
    output logic cpu_wait_o,
    output logic bus_mreq_no,
    output logic bus_iorq_no,
    output logic bus_rd_no,
    output logic bus_wr_no
);
    import pacer_pkg::*;

    localparam int MAX_CYC = (IO_CYC > MEM_CYC) ? IO_CYC : MEM_CYC;
    localparam int CNT_W   = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;

    typedef struct packed {
        logic             active;
        logic             turbo;
        acc_attr_t        attr;
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t           st_q, st_d;
    acc_attr_t        in_attr, cur;
    logic             stretch;
    logic [CNT_W-1:0] load;
    logic             vw_s;
    logic             vhold;
    logic             drive;

    pacer_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_vsync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (vwait_ni),
        .q_o   (vw_s)
    );

    assign in_attr = '{ext: tgt_ext_i, io: cpu_io_i, wr: cpu_wr_i, vdata: tgt_vdata_i};

    pacer_len #(.MEM_CYC(MEM_CYC), .IO_CYC(IO_CYC), .CNT_W(CNT_W)) u_len (
        .turbo_i  (st_q.turbo),
        .ext_i    (tgt_ext_i),
        .io_i     (cpu_io_i),
        .stretch_o(stretch),
        .load_o   (load)
    );

    always_comb begin
        st_d       = st_q;
        cur        = st_q.active ? st_q.attr : in_attr;
        vhold      = st_q.active & st_q.attr.ext & st_q.attr.io & st_q.attr.vdata
                   & vwait_en_i & ~vw_s;
        cpu_wait_o = 1'b0;

        if (!st_q.active) begin
            st_d.turbo = turbo_en_i;
            if (cpu_req_i && stretch) begin
                cpu_wait_o  = 1'b1;
                st_d.active = 1'b1;
                st_d.attr   = in_attr;
                st_d.cnt    = load;
            end
        end else begin
            cpu_wait_o = (st_q.cnt != '0) | vhold;
            if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
            if (!cpu_wait_o)    st_d.active = 1'b0;
        end

        drive       = (st_q.active | (cpu_req_i & stretch)) & cur.ext;
        bus_mreq_no = ~(drive & ~cur.io);
        bus_iorq_no = ~(drive &  cur.io);
        bus_rd_no   = ~(drive & ~cur.wr);
        bus_wr_no   = ~(drive &  cur.wr);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pacer_chk.sv
module pacer_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic req_i,
    input logic wait_i,
    input logic mreq_n_i,
    input logic iorq_n_i,
    input logic rd_n_i,
    input logic wr_n_i,
    input logic active_i,
    input logic cnt_nz_i,
    input logic hold_i
);
    // R3
    strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({~mreq_n_i, ~iorq_n_i}) && $onehot0({~rd_n_i, ~wr_n_i}));

    // R4
    cmd_has_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rd_n_i || !wr_n_i) |-> (!mreq_n_i || !iorq_n_i));

    // R1
    idle_no_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!active_i && !req_i) |-> (!wait_i && mreq_n_i && iorq_n_i));

    // R6
    vhold_waits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold_i |-> wait_i);

    // R3
    count_waits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active_i && cnt_nz_i) |-> wait_i);

    // R8
    release_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active_i && !wait_i) |=> !active_i);
endmodule

bind turbo_bus_pacer pacer_chk u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (cpu_req_i),
    .wait_i  (cpu_wait_o),
    .mreq_n_i(bus_mreq_no),
    .iorq_n_i(bus_iorq_no),
    .rd_n_i  (bus_rd_no),
    .wr_n_i  (bus_wr_no),
    .active_i(st_q.active),
    .cnt_nz_i(st_q.cnt != '0),
    .hold_i  (vhold)
);

// File: tb/turbo_bus_pacer_tb.sv
`timescale 1ns/100ps
module turbo_bus_pacer_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic turbo_en = 1'b0, cpu_req = 1'b0, cpu_io = 1'b0, cpu_wr = 1'b0;
    logic tgt_ext = 1'b0, tgt_vdata = 1'b0, vwait_en = 1'b0, vwait_n = 1'b1;
    logic cpu_wait, mreq_n, iorq_n, rd_n, wr_n;

    int  n_chk = 0, n_bad = 0;
    bit  model_turbo = 1'b0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    turbo_bus_pacer u_dut (
        .clk_i(clk), .rst_ni(rst_n), .turbo_en_i(turbo_en), .cpu_req_i(cpu_req),
        .cpu_io_i(cpu_io), .cpu_wr_i(cpu_wr), .tgt_ext_i(tgt_ext),
        .tgt_vdata_i(tgt_vdata), .vwait_en_i(vwait_en), .vwait_ni(vwait_n),
        .cpu_wait_o(cpu_wait), .bus_mreq_no(mreq_n), .bus_iorq_no(iorq_n),
        .bus_rd_no(rd_n), .bus_wr_no(wr_n)
    );

    function automatic int exp_len(bit turbo, bit ext, bit io, bit vd, bit ven, int rel);
        int base = (turbo && !ext) ? 1 : (io ? 6 : 4);
        if (rel >= 0 && ven && ext && io && vd && (rel + 3) > base) return rel + 3;
        return base;
    endfunction

    function automatic logic [3:0] exp_strb(bit ext, bit io, bit wr);
        if (!ext) return 4'b1111;
        return {io, ~io, wr, ~wr};   // {mreq_n, iorq_n, rd_n, wr_n}
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_mode(bit t, bit vn);
        @(negedge clk);
        cpu_req = 1'b0; turbo_en = t; vwait_n = vn; model_turbo = t;
        @(negedge clk);
    endtask

    task automatic do_acc(bit ext, bit io, bit wr, bit vd, bit ven, int rel,
                          bit tog, bit idle_after, string req);
        int n = 0;
        int e = exp_len(model_turbo, ext, io, vd, ven, rel);
        logic [3:0] es = exp_strb(ext, io, wr);
        logic [3:0] bad_s = 4'b0000;
        bit s_ok = 1'b1;
        @(negedge clk);
        cpu_req = 1'b1; tgt_ext = ext; cpu_io = io; cpu_wr = wr;
        tgt_vdata = vd; vwait_en = ven;
        if (rel >= 0) fork
            begin repeat (rel) @(negedge clk); vwait_n = 1'b1; end
        join_none
        forever begin
            #1;
            n++;
            if ({mreq_n, iorq_n, rd_n, wr_n} != es) begin
                s_ok = 1'b0; bad_s = {mreq_n, iorq_n, rd_n, wr_n};
            end
            if (!cpu_wait || n > 64) break;
            @(negedge clk);
            if (tog && n == 1) begin turbo_en = ~turbo_en; model_turbo = ~model_turbo; end
        end
        check(n == e, {req, " length"}, n, e);
        check(s_ok, {req, " strobes"}, int'(bad_s), int'(es));
        if (idle_after) begin
            @(negedge clk);
            cpu_req = 1'b0;
            #1;
            check({cpu_wait, mreq_n, iorq_n, rd_n, wr_n} == 5'b01111, "R8 idle after release",
                  int'({cpu_wait, mreq_n, iorq_n, rd_n, wr_n}), 15);
        end
    endtask

    initial begin
        #(5 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int rnd;
        rnd = $urandom(32'd20170820);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1: idle outputs after reset
        check({cpu_wait, mreq_n, iorq_n, rd_n, wr_n} == 5'b01111, "R1 reset outputs",
              int'({cpu_wait, mreq_n, iorq_n, rd_n, wr_n}), 15);
        // R1 R5: reset mode is compatibility, internal memory takes 4 cycles
        model_turbo = 1'b0;
        do_acc(0, 0, 0, 0, 0, -1, 0, 1, "R1 compat after reset");
        do_acc(0, 1, 1, 0, 0, -1, 0, 1, "R5 compat internal io");
        // R3 R4 in compatibility mode
        do_acc(1, 0, 1, 0, 0, -1, 0, 1, "R3 ext mem write compat");
        do_acc(1, 1, 0, 0, 0, -1, 0, 1, "R4 ext io read compat");
        // R2 turbo internal
        set_mode(1, 1);
        do_acc(0, 0, 0, 0, 0, -1, 0, 1, "R2 turbo internal mem");
        do_acc(0, 1, 1, 0, 0, -1, 0, 1, "R2 turbo internal io");
        do_acc(1, 0, 0, 0, 0, -1, 0, 1, "R3 ext mem read turbo");
        do_acc(1, 1, 1, 0, 0, -1, 0, 1, "R4 ext io write turbo");
        // R6 video wait extends data-port access
        set_mode(1, 0);
        do_acc(1, 1, 1, 1, 1, 9, 0, 1, "R6 vwait release at 9");
        set_mode(1, 0);
        do_acc(1, 1, 0, 1, 1, 3, 0, 1, "R6 vwait release at 3");
        // R7 ignored cases
        set_mode(1, 0);
        do_acc(1, 1, 1, 0, 1, 10, 0, 1, "R7 register port");
        set_mode(1, 0);
        do_acc(1, 1, 1, 1, 0, 10, 0, 1, "R7 wait disabled");
        set_mode(1, 0);
        do_acc(1, 0, 1, 1, 1, 10, 0, 1, "R7 memory access");
        // R8 back to back
        set_mode(1, 1);
        do_acc(1, 0, 0, 0, 0, -1, 0, 0, "R8 first of pair");
        do_acc(1, 1, 1, 0, 0, -1, 0, 0, "R8 second of pair");
        do_acc(0, 0, 0, 0, 0, -1, 0, 1, "R8 third of chain");
        // R9 mode toggled mid-access
        set_mode(0, 1);
        do_acc(0, 0, 1, 0, 0, -1, 1, 1, "R9 toggle during compat access");
        do_acc(0, 0, 1, 0, 0, -1, 0, 1, "R9 turbo after idle");
        // random mix
        for (int i = 0; i < 60; i++) begin
            bit t, e, io, wr, vd, ven, hl;
            int rel;
            t = 1'($urandom); e = 1'($urandom); io = 1'($urandom); wr = 1'($urandom);
            vd = 1'($urandom); ven = 1'($urandom); hl = 1'($urandom);
            rel = hl ? int'($urandom % 13) : -1;
            set_mode(t, ~hl);
            do_acc(e, io, wr, vd, ven, rel, 0, 1, "R6 R7 R3 R4 random");
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule